// File: doc/BRIEF.md
# AHB Burst Packetizer

This block turns one multi-word transfer request from a processor core into legal AHB master traffic. A request gives a word-aligned start address, a word count, and a direction. The block splits the count into packets and issues each packet as a single word, a four-beat incrementing burst or an eight-beat incrementing burst. It always picks the largest packet that still fits the words left. Every transfer is 32 bits wide. Write data is fetched from the requester by word index during each data phase. Read data is handed back with its word index as each beat completes.

A burst can be broken off in two ways: the slave answers with a two-cycle RETRY or SPLIT, or the arbiter takes the grant away. In either case the words of that packet not yet completed are sent as separate single transfers. A word that got RETRY or SPLIT is re-issued as a NONSEQ single once the block owns the bus again. An ERROR response ends the request at once and raises an error flag. A successful request ends with a one-cycle done pulse.

Top module: `ahb_burst_packer`

## Requirements
- R1: Every non-idle transfer uses HBURST SINGLE (3'b000), INCR4 (3'b011) or INCR8 (3'b101), with HSIZE fixed at word (3'b010).
- R2: Packets are chosen largest first: an 8-beat burst while 8 or more words remain unissued, else a 4-beat burst while 4 or more remain, else a single. For example, 12 words give INCR8 then INCR4, 13 give INCR8, INCR4, SINGLE, and 7 give INCR4 and three singles.
- R3: The first beat of a packet is NONSEQ (2'b10) and later beats are SEQ (2'b11). Each SEQ address is the previous accepted address plus 4, and word i of a request goes to start address plus 4*i.
- R4: While HREADY is low during an OKAY data phase, the pending address, burst type and transfer type are held unchanged.
- R5: While HRESP is not OKAY (RETRY 2'b10, SPLIT 2'b11, ERROR 2'b01), HTRANS is IDLE. After a RETRY or SPLIT, the failed word and the rest of its packet are issued as NONSEQ singles, and no SEQ beat follows the failure.
- R6: If HGRANT is low at an edge where HREADY is high and beats of the current packet are still unissued, those beats are issued as NONSEQ singles after grant returns.
- R7: Words complete in index order. During the data phase of word i, wr_idx equals i and HWDATA equals wr_word. A completed read beat pulses rd_valid with rd_idx equal to i and rd_word equal to HRDATA.
- R8: req_ready is high exactly when no request is active. done pulses for one cycle, in the cycle after the last word completes with OKAY.
- R9: An ERROR response ends the request without done and sets err. err stays set until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | 32 | Word-aligned start address |
| req_count | input | CW | Number of words |
| req_write | input | 1 | 1 = write, 0 = read |
| wr_idx | output | CW | Index of the word in data phase |
| wr_word | input | 32 | Write data for wr_idx |
| rd_valid | output | 1 | Read word completed |
| rd_idx | output | CW | Index of the completed read word |
| rd_word | output | 32 | Completed read data |
| done | output | 1 | Request finished successfully (pulse) |
| err | output | 1 | Request aborted by ERROR |
| hbusreq | output | 1 | Bus request to arbiter |
| hgrant | input | 1 | Grant from arbiter |
| haddr | output | 32 | AHB address |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB direction |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type |
| hwdata | output | 32 | AHB write data |
| hrdata | input | 32 | AHB read data |
| hready | input | 1 | AHB transfer done |
| hresp | input | 2 | AHB response |

## Verification
The bench targets counts that force mixed packet sequences: 12, 13, 7 and 1 words. A planner that did not pick greedily, or that let a packet run past the count, shows up as a wrong burst list or an extra word. It sends RETRY and SPLIT in the middle of an INCR8 and takes grant away in the middle of another. A design that resumed the burst with SEQ would trip the address-step and no-SEQ checks. A design that lost or repeated the failed word would produce a completion list out of order or the wrong length. A slave with wait states catches addresses that move while HREADY is low. An ERROR case checks that done stays low and that the error flag clears on the next request.

// File: rtl/ahb_pk_pkg.sv
package ahb_pk_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [2:0] BU_SINGLE = 3'b000;
  localparam logic [2:0] BU_INCR4  = 3'b011;
  localparam logic [2:0] BU_INCR8  = 3'b101;

  localparam logic [1:0] RS_OKAY   = 2'b00;
  localparam logic [1:0] RS_ERROR  = 2'b01;
  localparam logic [1:0] RS_RETRY  = 2'b10;
  localparam logic [1:0] RS_SPLIT  = 2'b11;

  localparam logic [2:0] SZ_WORD   = 3'b010;

  // greedy packet length for the number of words still unissued
  function automatic logic [3:0] pick_len(input int unsigned rem);
    if (rem >= 8)      return 4'd8;
    else if (rem >= 4) return 4'd4;
    else               return 4'd1;
  endfunction

  function automatic logic [2:0] burst_of(input logic [3:0] len);
    case (len)
      4'd8:    return BU_INCR8;
      4'd4:    return BU_INCR4;
      default: return BU_SINGLE;
    endcase
  endfunction
endpackage

// File: rtl/ahb_pk_plan.sv
module ahb_pk_plan
  import ahb_pk_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [CW-1:0] rem,
  input  logic [3:0]    pkt_left,
  input  logic          broken,
  input  logic [2:0]    cur_burst,
  output logic [1:0]    plan_trans,
  output logic [2:0]    plan_burst,
  output logic [3:0]    pkt_left_nxt
);
  logic       fresh;
  logic [3:0] new_len;

  assign fresh   = (pkt_left == 4'd0);
  assign new_len = pick_len(32'(rem));

  always_comb begin
    if (fresh) begin
      plan_trans   = TR_NONSEQ;
      plan_burst   = burst_of(new_len);
      pkt_left_nxt = new_len - 4'd1;
    end else if (broken) begin
      plan_trans   = TR_NONSEQ;
      plan_burst   = BU_SINGLE;
      pkt_left_nxt = pkt_left - 4'd1;
    end else begin
      plan_trans   = TR_SEQ;
      plan_burst   = cur_burst;
      pkt_left_nxt = pkt_left - 4'd1;
    end
  end
endmodule

// File: rtl/ahb_pk_dphase.sv
module ahb_pk_dphase
  import ahb_pk_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          accept,
  input  logic          hready,
  input  logic [1:0]    hresp,
  input  logic [CW-1:0] a_idx,
  input  logic [CW-1:0] n,
  output logic          dp_valid,
  output logic [CW-1:0] dp_idx,
  output logic          word_ok,
  output logic          word_fail,
  output logic          word_err,
  output logic          last_ok
);
  logic [CW-1:0] cmp;
  logic          ends;

  assign ends      = hready && dp_valid;
  assign word_ok   = ends && (hresp == RS_OKAY);
  assign word_err  = ends && (hresp == RS_ERROR);
  assign word_fail = ends && ((hresp == RS_RETRY) || (hresp == RS_SPLIT));
  assign last_ok   = word_ok && ((cmp + 1'b1) == n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_idx   <= '0;
      cmp      <= '0;
    end else if (start) begin
      dp_valid <= 1'b0;
      cmp      <= '0;
    end else begin
      if (hready) begin
        dp_valid <= accept;
        dp_idx   <= a_idx;
      end
      if (word_ok) cmp <= cmp + 1'b1;
    end
  end
endmodule

// File: rtl/ahb_burst_packer.sv
module ahb_burst_packer
  import ahb_pk_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [31:0]   req_addr,
  input  logic [CW-1:0] req_count,
  input  logic          req_write,
  output logic [CW-1:0] wr_idx,
  input  logic [31:0]   wr_word,
  output logic          rd_valid,
  output logic [CW-1:0] rd_idx,
  output logic [31:0]   rd_word,
  output logic          done,
  output logic          err,
  output logic          hbusreq,
  input  logic          hgrant,
  output logic [31:0]   haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [31:0]   hwdata,
  input  logic [31:0]   hrdata,
  input  logic          hready,
  input  logic [1:0]    hresp
);
  logic          busy, own_q, wr_q, broken;
  logic [31:0]   base;
  logic [CW-1:0] n, a_idx, rem, dp_idx;
  logic [3:0]    pkt_left, pkt_left_nxt;
  logic [2:0]    cur_burst, plan_burst;
  logic [1:0]    plan_trans;
  logic          start, addr_act, accept, dp_valid;
  logic          word_ok, word_fail, word_err, last_ok;
  logic          grant_break;

  assign start    = req_valid && !busy;
  assign rem      = n - a_idx;
  assign addr_act = busy && own_q && (a_idx != n) && (hresp == RS_OKAY);
  assign accept   = addr_act && hready;
  // named event for the checker: grant lost with packet beats still unissued
  assign grant_break = busy && hready && !hgrant &&
                       (accept ? (pkt_left_nxt != 4'd0) : (pkt_left != 4'd0));

  ahb_pk_plan #(.CW(CW)) u_plan (
    .rem          (rem),
    .pkt_left     (pkt_left),
    .broken       (broken),
    .cur_burst    (cur_burst),
    .plan_trans   (plan_trans),
    .plan_burst   (plan_burst),
    .pkt_left_nxt (pkt_left_nxt)
  );

  ahb_pk_dphase #(.CW(CW)) u_dph (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .hready    (hready),
    .hresp     (hresp),
    .a_idx     (a_idx),
    .n         (n),
    .dp_valid  (dp_valid),
    .dp_idx    (dp_idx),
    .word_ok   (word_ok),
    .word_fail (word_fail),
    .word_err  (word_err),
    .last_ok   (last_ok)
  );

  assign req_ready = !busy;
  assign hbusreq   = busy;
  assign htrans    = addr_act ? plan_trans : TR_IDLE;
  assign hburst    = plan_burst;
  assign hsize     = SZ_WORD;
  assign hwrite    = wr_q;
  assign haddr     = base + (32'(a_idx) << 2);
  assign hwdata    = wr_word;
  assign wr_idx    = dp_idx;
  assign rd_idx    = dp_idx;
  assign rd_word   = hrdata;
  assign rd_valid  = word_ok && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      own_q     <= 1'b0;
      wr_q      <= 1'b0;
      broken    <= 1'b0;
      base      <= '0;
      n         <= '0;
      a_idx     <= '0;
      pkt_left  <= '0;
      cur_burst <= BU_SINGLE;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (hready) own_q <= hgrant;
      if (start) begin
        busy     <= (req_count != '0);
        base     <= req_addr;
        n        <= req_count;
        wr_q     <= req_write;
        a_idx    <= '0;
        pkt_left <= '0;
        broken   <= 1'b0;
        err      <= 1'b0;
        done     <= (req_count == '0);
      end else if (busy) begin
        if (word_err) begin
          busy     <= 1'b0;
          err      <= 1'b1;
          pkt_left <= '0;
          broken   <= 1'b0;
        end else if (word_fail) begin
          // rewind to the failed word; it rejoins the packet as a single
          a_idx    <= dp_idx;
          pkt_left <= pkt_left + 4'd1;
          broken   <= 1'b1;
        end else begin
          if (accept) begin
            a_idx    <= a_idx + 1'b1;
            pkt_left <= pkt_left_nxt;
            if (pkt_left == 4'd0) cur_burst <= plan_burst;
            if (pkt_left_nxt == 4'd0) broken <= 1'b0;
            else if (!hgrant)         broken <= 1'b1;
          end else if (grant_break) begin
            broken <= 1'b1;
          end
          if (last_ok) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ahb_pk_checker.sv
module ahb_pk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  htrans,
  input logic [2:0]  hburst,
  input logic [2:0]  hsize,
  input logic [31:0] haddr,
  input logic        hready,
  input logic [1:0]  hresp,
  input logic        word_fail,
  input logic        grant_break,
  input logic        done,
  input logic        err
);
  logic [31:0] last_addr;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      seen      <= 1'b0;
    end else if (htrans[1] && hready) begin
      last_addr <= haddr;
      seen      <= 1'b1;
    end
  end

  p_burst_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    htrans[1] |-> ((hburst == 3'b000 || hburst == 3'b011 || hburst == 3'b101) && hsize == 3'b010));

  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> (seen && haddr == last_addr + 32'd4));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && !hready && hresp == 2'b00) |=>
      ($stable(haddr) && $stable(hburst) && (hresp != 2'b00 || $stable(htrans))));

  p_idle_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp != 2'b00) |-> (htrans == 2'b00));

  p_no_seq_after_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_fail |=> (htrans != 2'b11));

  p_no_seq_after_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_break |=> (htrans != 2'b11));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind ahb_burst_packer ahb_pk_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .htrans      (htrans),
  .hburst      (hburst),
  .hsize       (hsize),
  .haddr       (haddr),
  .hready      (hready),
  .hresp       (hresp),
  .word_fail   (word_fail),
  .grant_break (grant_break),
  .done        (done),
  .err         (err)
);

// File: tb/sim_ahb_burst_packer.sv
module sim_ahb_burst_packer;
  localparam int CW = 8;
  localparam logic [2:0] B1 = 3'b000, B4 = 3'b011, B8 = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic req_ready, rd_valid, done, err, hbusreq, hwrite;
  logic [CW-1:0] wr_idx, rd_idx;
  logic [31:0] wr_word, rd_word, haddr, hwdata;
  logic [31:0] hrdata = '0;
  logic [1:0] htrans;
  logic [2:0] hsize, hburst;
  logic hgrant = 1'b1, hready = 1'b1;
  logic [1:0] hresp = 2'b00;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign wr_word = 32'hA5A5_0000 | 32'(wr_idx);

  ahb_burst_packer #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .req_write(req_write),
    .wr_idx(wr_idx), .wr_word(wr_word), .rd_valid(rd_valid), .rd_idx(rd_idx),
    .rd_word(rd_word), .done(done), .err(err), .hbusreq(hbusreq), .hgrant(hgrant),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  // scenario knobs
  int wait_mod = 0, wait_n = 0, fail_ord = -1, gdrop_ord = -1;
  logic [1:0] fail_code = 2'b10;
  // slave state and logs
  int ord = 0, waits = 0, grant_off = 0, npk = 0, ncw = 0, nacc = 0;
  int ndone = 0, rd_bad = 0, nrd = 0, hold_bad = 0, seq_bad = 0;
  logic dph_v = 1'b0, dph_wr = 1'b0, rstage = 1'b0, hold_pend = 1'b0;
  logic [31:0] dph_addr = '0, hold_addr = '0, last_acc = '0, cur_base = '0;
  int dph_ord = 0;
  logic [1:0] code_act = 2'b00;
  logic [2:0] pk_burst [0:63];
  logic [31:0] cw_addr [0:255];
  logic [31:0] cw_data [0:255];

  function automatic logic [31:0] rpat(input logic [31:0] a);
    return ~a ^ 32'h1234_0000;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) ndone++;
      if (grant_off > 0) begin
        grant_off--;
        if (grant_off == 0) hgrant = 1'b1;
      end
      if (dph_v) begin
        if (rstage) begin hready = 1'b1; hresp = code_act; end
        else if (waits > 0) begin hready = 1'b0; hresp = 2'b00; waits--; end
        else if (dph_ord == fail_ord) begin
          hready = 1'b0; hresp = fail_code; code_act = fail_code; rstage = 1'b1;
        end else begin hready = 1'b1; hresp = 2'b00; hrdata = rpat(dph_addr); end
      end else begin
        hready = 1'b1; hresp = 2'b00;
      end
      #1;
      if (hold_pend && hresp == 2'b00 && !(htrans[1] && haddr == hold_addr)) hold_bad++;
      hold_pend = htrans[1] && !hready && hresp == 2'b00;
      hold_addr = haddr;
      if (rd_valid) begin
        nrd++;
        if (rd_word != rpat(cur_base + 32'(rd_idx) * 4)) rd_bad++;
      end
      if (hready) begin
        if (dph_v) begin
          if (hresp == 2'b00) begin
            cw_addr[ncw] = dph_addr;
            cw_data[ncw] = dph_wr ? hwdata : hrdata;
            ncw++;
          end else begin
            rstage = 1'b0;
            if (hresp == 2'b11) begin hgrant = 1'b0; grant_off = 3; end
          end
        end
        if (htrans[1]) begin
          if (htrans == 2'b11 && haddr != last_acc + 32'd4) seq_bad++;
          last_acc = haddr;
          dph_v = 1'b1; dph_addr = haddr; dph_wr = hwrite; dph_ord = ord;
          waits = (wait_mod != 0 && (ord % wait_mod) == wait_mod - 1) ? wait_n : 0;
          if (htrans == 2'b10) begin pk_burst[npk] = hburst; npk++; end
          if (ord == gdrop_ord) begin hgrant = 1'b0; grant_off = 4; end
          ord++; nacc++;
        end else dph_v = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic prep(input int wm, input int wn, input int fo, input logic [1:0] fc,
                      input int go);
    @(posedge clk);
    wait_mod = wm; wait_n = wn; fail_ord = fo; fail_code = fc; gdrop_ord = go;
    ord = 0; npk = 0; ncw = 0; nacc = 0; ndone = 0; rd_bad = 0; nrd = 0;
    hold_bad = 0; seq_bad = 0;
  endtask

  task automatic run_req(input logic [31:0] a, input int cnt, input bit w);
    int cyc = 0;
    @(negedge clk);
    cur_base = a;
    req_valid = 1'b1; req_addr = a; req_count = CW'(cnt); req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && !err && cyc < 2000) begin @(negedge clk); cyc++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_words(input string req, input logic [31:0] a, input int cnt,
                             input bit w);
    int bad = 0;
    check(ncw == cnt, req, "completed words", ncw, cnt);
    for (int i = 0; i < cnt && i < ncw; i++) begin
      if (cw_addr[i] != a + 32'(i) * 4) bad++;
      if (w && cw_data[i] != (32'hA5A5_0000 | 32'(i))) bad++;
      if (!w && cw_data[i] != rpat(a + 32'(i) * 4)) bad++;
    end
    check(bad == 0, req, "word order/data mismatches", bad, 0);
    check(seq_bad == 0, "R3", "SEQ address steps", seq_bad, 0);
  endtask

  task automatic check_pk(input string req, input int n, input logic [23:0] codes);
    int bad = 0;
    check(npk == n, req, "packet count", npk, n);
    for (int i = 0; i < n && i < npk; i++)
      if (pk_burst[i] != codes[3*i +: 3]) bad++;
    check(bad == 0, req, "packet burst types", bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R8", "req_ready after reset", int'(req_ready), 1);
    check(htrans == 2'b00, "R5", "htrans idle after reset", int'(htrans), 0);
    check(done == 1'b0 && err == 1'b0, "R9", "done/err after reset", int'({done, err}), 0);
  endtask

  task automatic t_write12();
    prep(0, 0, -1, 2'b10, -1);
    run_req(32'h0000_1000, 12, 1'b1);
    check_pk("R2", 2, {18'd0, B4, B8});
    check(nacc == 12, "R3", "beats accepted (10 SEQ)", nacc, 12);
    check_words("R7", 32'h0000_1000, 12, 1'b1);
    check(ndone == 1, "R8", "done pulses", ndone, 1);
    check(hsize == 3'b010, "R1", "hsize word", int'(hsize), 2);
  endtask

  task automatic t_read13_waits();
    prep(3, 2, -1, 2'b10, -1);
    run_req(32'h0000_2040, 13, 1'b0);
    check_pk("R2", 3, {15'd0, B1, B4, B8});
    check_words("R7", 32'h0000_2040, 13, 1'b0);
    check(nrd == 13 && rd_bad == 0, "R7", "read deliveries good", nrd - rd_bad, 13);
    check(hold_bad == 0, "R4", "held address violations", hold_bad, 0);
    check(ndone == 1 && err == 1'b0, "R8", "done once, no err", ndone, 1);
  endtask

  task automatic t_seven_and_one();
    prep(0, 0, -1, 2'b10, -1);
    run_req(32'h0000_3000, 7, 1'b1);
    check_pk("R2", 4, {12'd0, B1, B1, B1, B4});
    check_words("R7", 32'h0000_3000, 7, 1'b1);
    prep(0, 0, -1, 2'b10, -1);
    run_req(32'h0000_3100, 1, 1'b0);
    check_pk("R2", 1, {21'd0, B1});
    check(ndone == 1, "R8", "done for single", ndone, 1);
    check(req_ready == 1'b1, "R8", "req_ready when idle", int'(req_ready), 1);
  endtask

  task automatic t_retry();
    prep(0, 0, 2, 2'b10, -1);
    run_req(32'h0000_4000, 8, 1'b1);
    check_pk("R5", 7, {3'd0, B1, B1, B1, B1, B1, B1, B8});
    check_words("R5", 32'h0000_4000, 8, 1'b1);
    check(ndone == 1, "R5", "done after retry", ndone, 1);
  endtask

  task automatic t_split();
    prep(2, 1, 4, 2'b11, -1);
    run_req(32'h0000_5000, 8, 1'b0);
    check_pk("R5", 5, {9'd0, B1, B1, B1, B1, B8});
    check_words("R5", 32'h0000_5000, 8, 1'b0);
    check(hold_bad == 0, "R4", "held address violations", hold_bad, 0);
  endtask

  task automatic t_grant_drop();
    prep(0, 0, -1, 2'b10, 2);
    run_req(32'h0000_6000, 8, 1'b1);
    check_pk("R6", 6, {6'd0, B1, B1, B1, B1, B1, B8});
    check_words("R6", 32'h0000_6000, 8, 1'b1);
    check(ndone == 1, "R6", "done after grant loss", ndone, 1);
  endtask

  task automatic t_error();
    prep(0, 0, 1, 2'b01, -1);
    run_req(32'h0000_7000, 4, 1'b1);
    check(err == 1'b1, "R9", "err set", int'(err), 1);
    check(ndone == 0, "R9", "no done on error", ndone, 0);
    check(ncw == 1, "R9", "words before error", ncw, 1);
    check(req_ready == 1'b1, "R9", "idle after error", int'(req_ready), 1);
    prep(0, 0, -1, 2'b10, -1);
    run_req(32'h0000_7100, 1, 1'b1);
    check(err == 1'b0, "R9", "err cleared by next request", int'(err), 0);
    check(ndone == 1, "R9", "next request completes", ndone, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write12();
    t_read13_waits();
    t_seven_and_one();
    t_retry();
    t_split();
    t_grant_drop();
    t_error();
    finish_run();
  end
endmodule